// File: doc/BRIEF.md
# Watchdog Register Unlock Gate

This block sits between a bus write port and a watchdog's protected control registers. Software opens the gate by writing two key values, in order, to the command offset. The gate then lets exactly one protected write through, and that write closes the gate again. The gate observes every write on the bus: offset, data, access size and write enable. From these it produces qualified one-cycle strobes that load the stage-1 preload, load the stage-2 preload, or issue a keep-alive and flag-clear command.

The gate uses three states: idle, armed and open. Key writes are recognised at any supported access size. Byte writes can move the unlock sequence forward but can never use an open gate. A write that reaches an open gate at an offset or size with no protected register behind it still closes the gate, and it produces no strobe. The strobes are combinational in the cycle of the accepted write, so the register file behind the gate updates on that same clock edge.

Top module: `wdt_unlock_gate`

## Requirements
- R1: After reset the gate is idle. A half or word write to any protected target, with no unlock sequence before it, raises no strobe.
- R2: A write to offset 0xC whose value is 0x80 moves the gate to armed from any state, at any supported size. The value is compared zero-extended to the access width, so a half write of 0x0080 and a word write of 0x00000080 both count as 0x80. If the gate was open, it loses that opening.
- R3: A write of 0x86 to offset 0xC opens the gate only when the gate is armed. In the idle or open state the same write is ignored and the state is kept.
- R4: When the gate is open, the first half (size 01) or word (size 10) write that is not a key write is granted, and the gate returns to idle. A second identical write is not granted.
- R5: A granted word write to offset 0x0 pulses `pre1_ld_o`, and one to offset 0x4 pulses `pre2_ld_o`. In both cases `preload_o` carries data bits 19:0.
- R6: A granted half write to offset 0xC pulses `cmd_o`. With it, `kick_o` equals data bit 8 and `clr_o` equals the OR of data bits 9 and 12.
- R7: A byte write (size 00) that is not a key write raises no strobe and leaves the gate open if it was open.
- R8: A non-key write made while the gate is idle or armed is ignored and leaves the state unchanged.
- R9: A granted write with no protected target closes the gate and raises no strobe. Examples are a word write to 0xC, a half write to 0x0, and a word write to 0x8.
- R10: At most one of `pre1_ld_o`, `pre2_ld_o`, `cmd_o` is high at a time. Each is high only during a cycle with `wr_en_i` high.
- R11: Writes with the reserved size code 11 have no effect on the state and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 4 | Byte offset of the write |
| wr_data_i | input | 32 | Write data, right-aligned to the access size |
| wr_size_i | input | 2 | Access size: 00 byte, 01 half, 10 word, 11 reserved |
| pre1_ld_o | output | 1 | Load stage-1 preload |
| pre2_ld_o | output | 1 | Load stage-2 preload |
| preload_o | output | 20 | Preload value, valid with either load strobe |
| cmd_o | output | 1 | Granted command write |
| kick_o | output | 1 | Keep-alive request, valid with cmd_o |
| clr_o | output | 1 | Clear previous-expiry flag, valid with cmd_o |

## Verification
The hardest condition to reach from the ports is a gate that stays open across writes that must not consume it. Examples are byte writes, a repeated second key, and reserved-size writes, each followed by a write that then proves the opening survived. Hidden state is never read. Instead, each scenario ends with a probe write whose strobe shows whether the gate was idle, armed or open at that point. Sequences that interleave the two keys with stray writes at every size show that the state is held or lost exactly as the requirements state.

// File: rtl/wug_pkg.sv
package wug_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } wsize_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_OPEN = 2'd2
  } gate_st_e;
endpackage

// File: rtl/wug_key_decode.sv
module wug_key_decode
  import wug_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          DATA_W  = 32,
  parameter logic [ADDR_W-1:0] KEY_OFF = 4'hC,
  parameter logic [7:0]  KEY1    = 8'h80,
  parameter logic [7:0]  KEY2    = 8'h86
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  wsize_e            wr_size_i,
  output logic              valid_o,
  output logic              key1_o,
  output logic              key2_o
);
  logic [DATA_W-1:0] val;

  always_comb begin
    unique case (wr_size_i)
      SZ_BYTE: val = DATA_W'(wr_data_i[7:0]);
      SZ_HALF: val = DATA_W'(wr_data_i[15:0]);
      default: val = wr_data_i;
    endcase
  end

  assign valid_o = wr_en_i && (wr_size_i != SZ_RSVD);
  assign key1_o  = valid_o && (wr_addr_i == KEY_OFF) && (val == DATA_W'(KEY1));
  assign key2_o  = valid_o && (wr_addr_i == KEY_OFF) && (val == DATA_W'(KEY2));
endmodule

// File: rtl/wug_seq.sv
module wug_seq
  import wug_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   valid_i,
  input  logic   key1_i,
  input  logic   key2_i,
  input  wsize_e size_i,
  output logic   grant_o
);
  gate_st_e state_q, state_d;

  // byte writes never use the opening
  assign grant_o = valid_i && !key1_i && !key2_i && (state_q == ST_OPEN) &&
                   (size_i != SZ_BYTE);

  always_comb begin
    state_d = state_q;
    if (key1_i)                              state_d = ST_ARM;
    else if (key2_i && state_q == ST_ARM)    state_d = ST_OPEN;
    else if (grant_o)                        state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/wug_route.sv
module wug_route
  import wug_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          PRELOAD_W = 20,
  parameter logic [ADDR_W-1:0] PRE1_OFF = 4'h0,
  parameter logic [ADDR_W-1:0] PRE2_OFF = 4'h4,
  parameter logic [ADDR_W-1:0] CMD_OFF  = 4'hC
) (
  input  logic                 grant_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  wsize_e               size_i,
  input  logic [PRELOAD_W-1:0] field_i,
  input  logic                 kick_bit_i,
  input  logic                 clr_bit_a_i,
  input  logic                 clr_bit_b_i,
  output logic                 pre1_ld_o,
  output logic                 pre2_ld_o,
  output logic [PRELOAD_W-1:0] preload_o,
  output logic                 cmd_o,
  output logic                 kick_o,
  output logic                 clr_o
);
  logic word_g;
  assign word_g    = grant_i && (size_i == SZ_WORD);
  assign pre1_ld_o = word_g && (addr_i == PRE1_OFF);
  assign pre2_ld_o = word_g && (addr_i == PRE2_OFF);
  assign preload_o = (pre1_ld_o || pre2_ld_o) ? field_i : '0;
  assign cmd_o     = grant_i && (size_i == SZ_HALF) && (addr_i == CMD_OFF);
  assign kick_o    = cmd_o && kick_bit_i;
  assign clr_o     = cmd_o && (clr_bit_a_i || clr_bit_b_i);
endmodule

// File: rtl/wdt_unlock_gate.sv
module wdt_unlock_gate
  import wug_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PRELOAD_W = 20,
  parameter int KICK_BIT  = 8,
  parameter int CLR_BIT_A = 9,
  parameter int CLR_BIT_B = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [1:0]           wr_size_i,
  output logic                 pre1_ld_o,
  output logic                 pre2_ld_o,
  output logic [PRELOAD_W-1:0] preload_o,
  output logic                 cmd_o,
  output logic                 kick_o,
  output logic                 clr_o
);
  wsize_e size;
  logic   valid, key1, key2, grant;

  assign size = wsize_e'(wr_size_i);

  wug_key_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .wr_size_i(size),
    .valid_o  (valid),
    .key1_o   (key1),
    .key2_o   (key2)
  );

  wug_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid),
    .key1_i (key1),
    .key2_i (key2),
    .size_i (size),
    .grant_o(grant)
  );

  wug_route #(.ADDR_W(ADDR_W), .PRELOAD_W(PRELOAD_W)) u_route (
    .grant_i    (grant),
    .addr_i     (wr_addr_i),
    .size_i     (size),
    .field_i    (wr_data_i[PRELOAD_W-1:0]),
    .kick_bit_i (wr_data_i[KICK_BIT]),
    .clr_bit_a_i(wr_data_i[CLR_BIT_A]),
    .clr_bit_b_i(wr_data_i[CLR_BIT_B]),
    .pre1_ld_o  (pre1_ld_o),
    .pre2_ld_o  (pre2_ld_o),
    .preload_o  (preload_o),
    .cmd_o      (cmd_o),
    .kick_o     (kick_o),
    .clr_o      (clr_o)
  );
endmodule

// File: rtl/wug_chk.sv
module wug_chk
  import wug_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [1:0]        wr_size_i,
  input logic              pre1_ld_o,
  input logic              pre2_ld_o,
  input logic              cmd_o,
  input logic              kick_o,
  input logic              clr_o,
  input gate_st_e          state_q
);
  logic any_stb;
  assign any_stb = pre1_ld_o | pre2_ld_o | cmd_o;

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pre1_ld_o, pre2_ld_o, cmd_o})); // R10
  AST_STROBE_NEEDS_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stb |-> wr_en_i); // R10
  AST_GRANT_WHEN_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stb |-> state_q == ST_OPEN); // R4
  AST_GRANT_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stb |=> state_q == ST_IDLE); // R4
  AST_KEY1_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'b00 && wr_addr_i == 4'hC && wr_data_i[7:0] == 8'h80)
    |=> state_q == ST_ARM); // R2
  AST_IDLE_BUS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(state_q)); // R8
  AST_BYTE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'b00) |-> !any_stb); // R7
  AST_RSVD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'b11) |=> $stable(state_q)); // R11
  AST_CMD_QUALIFIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_o || clr_o) |-> cmd_o); // R6
endmodule

bind wdt_unlock_gate wug_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .wr_size_i(wr_size_i),
  .pre1_ld_o(pre1_ld_o),
  .pre2_ld_o(pre2_ld_o),
  .cmd_o    (cmd_o),
  .kick_o   (kick_o),
  .clr_o    (clr_o),
  .state_q  (u_seq.state_q)
);

// File: tb/sim_wdt_unlock_gate.sv
module sim_wdt_unlock_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_size = '0;
  logic        pre1, pre2, cmd, kick, clr;
  logic [19:0] preload;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // sampled strobe vector {pre1,pre2,cmd,kick,clr} and preload
  logic [4:0]  s_stb;
  logic [19:0] s_pre;

  localparam logic [1:0] B = 2'b00, H = 2'b01, W = 2'b10, X = 2'b11;

  always #2.5 clk = ~clk;

  wdt_unlock_gate u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_size_i(wr_size), .pre1_ld_o(pre1),
    .pre2_ld_o(pre2), .preload_o(preload), .cmd_o(cmd), .kick_o(kick),
    .clr_o(clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one write cycle; strobes sampled mid-cycle before the committing edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [1:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_size = s;
    #1;
    s_stb = {pre1, pre2, cmd, kick, clr};
    s_pre = preload;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic unlock(input logic [1:0] s);
    wr(4'hC, 32'h80, s);
    wr(4'hC, 32'h86, s);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 idle outputs", {27'd0, pre1, pre2, cmd, kick, clr}, 32'd0);
    wr(4'h0, 32'h12345, W);
    chk("R1 word 0x0 locked", {27'd0, s_stb}, 32'd0);
    wr(4'hC, 32'h100, H);
    chk("R1 half 0xC locked", {27'd0, s_stb}, 32'd0);
  endtask

  task automatic t_pre1_once();
    unlock(B);
    wr(4'h0, 32'hABCDE123, W);
    chk("R5 pre1 strobe", {27'd0, s_stb}, 32'b10000);
    chk("R5 pre1 data", {12'd0, s_pre}, 32'hDE123);
    wr(4'h0, 32'hABCDE123, W);
    chk("R4 single grant", {27'd0, s_stb}, 32'd0);
  endtask

  task automatic t_pre2_half_keys();
    unlock(H);
    wr(4'h4, 32'hFFF54321, W);
    chk("R2 half keys -> pre2", {27'd0, s_stb}, 32'b01000);
    chk("R5 pre2 data", {12'd0, s_pre}, 32'h54321);
  endtask

  task automatic t_cmd();
    unlock(W);
    wr(4'hC, 32'h0100, H);
    chk("R6 kick", {27'd0, s_stb}, 32'b00110);
    unlock(B);
    wr(4'hC, 32'h1000, H);
    chk("R6 clr bit12", {27'd0, s_stb}, 32'b00101);
    unlock(B);
    wr(4'hC, 32'h0200, H);
    chk("R6 clr bit9", {27'd0, s_stb}, 32'b00101);
    unlock(B);
    wr(4'hC, 32'h0000, H);
    chk("R6 plain cmd", {27'd0, s_stb}, 32'b00100);
  endtask

  task automatic t_key2_rules();
    wr(4'hC, 32'h86, B);
    wr(4'h0, 32'h1, W);
    chk("R3 key2 from idle ignored", {27'd0, s_stb}, 32'd0);
    unlock(B);
    wr(4'hC, 32'h86, B);
    wr(4'h0, 32'h2, W);
    chk("R3 key2 while open keeps open", {27'd0, s_stb}, 32'b10000);
    unlock(B);
    wr(4'hC, 32'h80, B);
    wr(4'h0, 32'h3, W);
    chk("R2 key1 while open re-arms", {27'd0, s_stb}, 32'd0);
  endtask

  task automatic t_byte();
    unlock(B);
    wr(4'h0, 32'h55, B);
    chk("R7 byte no strobe", {27'd0, s_stb}, 32'd0);
    wr(4'hC, 32'h100, B);
    chk("R7 byte 0xC no strobe", {27'd0, s_stb}, 32'd0);
    wr(4'h0, 32'h77, W);
    chk("R7 open survives bytes", {27'd0, s_stb}, 32'b10000);
  endtask

  task automatic t_before_unlock();
    wr(4'hC, 32'h80, B);
    wr(4'h4, 32'h9, W);
    chk("R8 stray while armed", {27'd0, s_stb}, 32'd0);
    wr(4'hC, 32'h86, B);
    wr(4'h4, 32'h9, W);
    chk("R8 armed kept", {27'd0, s_stb}, 32'b01000);
  endtask

  task automatic t_unmapped();
    unlock(B);
    wr(4'hC, 32'h100, W);
    chk("R9 word 0xC no strobe", {27'd0, s_stb}, 32'd0);
    wr(4'h0, 32'h1, W);
    chk("R9 word 0xC consumed", {27'd0, s_stb}, 32'd0);
    unlock(B);
    wr(4'h0, 32'h1, H);
    wr(4'h0, 32'h1, W);
    chk("R9 half 0x0 consumed", {27'd0, s_stb}, 32'd0);
    unlock(B);
    wr(4'h8, 32'h1, W);
    wr(4'h4, 32'h1, W);
    chk("R9 word 0x8 consumed", {27'd0, s_stb}, 32'd0);
  endtask

  task automatic t_pulse();
    unlock(B);
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 4'h0; wr_data = 32'h5; wr_size = W;
    #1;
    chk("R10 no strobe without wr_en", {27'd0, pre1, pre2, cmd, kick, clr}, 32'd0);
    wr(4'h0, 32'h5, W);
    chk("R10 strobe with write", {27'd0, s_stb}, 32'b10000);
    @(negedge clk);
    #1;
    chk("R10 strobe drops next cycle", {27'd0, pre1, pre2, cmd, kick, clr}, 32'd0);
  endtask

  task automatic t_reserved();
    wr(4'hC, 32'h80, B);
    wr(4'hC, 32'h86, X);
    wr(4'h0, 32'h1, W);
    chk("R11 rsvd key2 ignored", {27'd0, s_stb}, 32'd0);
    unlock(B);
    wr(4'h0, 32'h1, X);
    chk("R11 rsvd no strobe", {27'd0, s_stb}, 32'd0);
    wr(4'h0, 32'h1, W);
    chk("R11 rsvd not consumed", {27'd0, s_stb}, 32'b10000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_pre1_once();
    t_pre2_half_keys();
    t_cmd();
    t_key2_rules();
    t_byte();
    t_before_unlock();
    t_unmapped();
    t_pulse();
    t_reserved();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule